// File: doc/BRIEF.md
# Upper Memory Shadow Attribute Decoder

This block turns the chipset's three shadow configuration bytes and the 16 KB block number of a memory access in the top 256 KB of the 1 MB address space into access attributes: where a read is served from (on-board DRAM or the expansion bus) and what happens to a write (stored in DRAM, sent to the bus, or dropped). The memory controller uses these attributes to steer each cycle.

The 64 KB segment at the top holds the system firmware. Below it, four 16 KB segments at 0xC0000 to 0xCFFFF serve adapter firmware, and eight 16 KB segments at 0xD0000 to 0xEFFFF are general upper memory. Each small segment has its own enable bit, and a shared fallback bit decides whether disabled segments still take protected writes into DRAM. The decode is combinational; a parameter adds one output register stage (on by default).

Top module: `shadow_attr_decode`

## Requirements
- R1: For a block number whose address lies below 0xC0000 (blk_i[5:4] not 2'b11), the outputs are rd_int_o=0, wr_int_o=0, wr_en_o=1 (read and write both on the bus).
- R2: For the firmware segment (blk_i[5:2]=4'b1111) with sys_cfg_i[7]=1, the outputs are rd_int_o=0, wr_int_o=1, wr_en_o=1.
- R3: For the firmware segment with sys_cfg_i[7]=0, the outputs are rd_int_o=1, wr_int_o=0, wr_en_o=0 (read from DRAM, write dropped).
- R4: Upper segment k (0 to 7) starts at 0xD0000 + k*0x4000 and is switched on by hi_seg_en_i[k]; a switched-on upper segment gives rd_int_o=1.
- R5: An upper segment's write is dropped (wr_int_o=0, wr_en_o=0) when its protect bit is 1 and goes to DRAM (wr_int_o=1, wr_en_o=1) when it is 0; the protect bit is sys_cfg_i[4] for segments below 0xE0000 and sys_cfg_i[3] for segments at or above 0xE0000.
- R6: A switched-off adapter or upper segment with lo_cfg_i[6]=1 gives rd_int_o=0 and the write outcome of its protect bit, as in R5 and R8.
- R7: A switched-off adapter or upper segment with lo_cfg_i[6]=0 gives rd_int_o=0, wr_int_o=0, wr_en_o=1.
- R8: Adapter segment k (0 to 3) at 0xC0000 + k*0x4000 is switched on by lo_cfg_i[k] and then gives rd_int_o=1; its protect bit is lo_cfg_i[5], with the write outcome encoding of R5.
- R9: With the output stage on, the outputs reflect the inputs of the previous clock edge, and while rst_n is low they are all 0.
- R10: Whenever wr_en_o is 0, wr_int_o is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_i | input | 6 | Address bits 19:14, the 16 KB block number |
| sys_cfg_i | input | 8 | Firmware mode (bit 7) and upper protect bits (bits 4 and 3) |
| hi_seg_en_i | input | 8 | Per-segment enables for 0xD0000 to 0xEFFFF |
| lo_cfg_i | input | 8 | Adapter enables (bits 3:0), adapter protect (bit 5), fallback mode (bit 6) |
| rd_int_o | output | 1 | 1 = read from DRAM, 0 = read from bus |
| wr_int_o | output | 1 | 1 = write to DRAM |
| wr_en_o | output | 1 | 0 = write dropped; 1 with wr_int_o=0 = write to bus |

## Verification
The hardest situation to reach is a mis-mapped segment: an enable or protect bit applied to a neighbouring 16 KB block, which random configuration bytes rarely expose because many bits are set at once. The stimulus therefore walks every block from 0xC0000 to 0xFFFFF under one-hot enable patterns combined with each protect and fallback setting, so a single lit bit must affect exactly one segment, and only afterwards mixes in random bytes.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    localparam int BLK_W      = 6;
    localparam int NUM_LO_SEG = 4;
    localparam int NUM_HI_SEG = 8;
    localparam int LO_IDX_W   = $clog2(NUM_LO_SEG);
    localparam int HI_IDX_W   = $clog2(NUM_HI_SEG);

    typedef enum logic [1:0] {
        RGN_OUTSIDE,
        RGN_ADAPTER,
        RGN_UPPER,
        RGN_FIRMWARE
    } region_t;

    typedef struct packed {
        logic rd_int;
        logic wr_int;
        logic wr_en;
    } attr_t;

    localparam attr_t ATTR_BUS  = '{rd_int: 1'b0, wr_int: 1'b0, wr_en: 1'b1};
    localparam attr_t ATTR_ZERO = '{rd_int: 1'b0, wr_int: 1'b0, wr_en: 1'b0};

endpackage

// File: rtl/shadow_region_sel.sv
module shadow_region_sel
    import shadow_pkg::*;
(
    input  logic [BLK_W-1:0]    blk,
    output region_t             region,
    output logic [HI_IDX_W-1:0] hi_idx,
    output logic [LO_IDX_W-1:0] lo_idx
);

    always_comb begin
        region = RGN_OUTSIDE;
        unique case (blk[5:2])
            4'b1100: region = RGN_ADAPTER;
            4'b1101: region = RGN_UPPER;
            4'b1110: region = RGN_UPPER;
            4'b1111: region = RGN_FIRMWARE;
            default: region = RGN_OUTSIDE;
        endcase
    end

    // Upper segments: D blocks map to 0..3, E blocks to 4..7.
    assign hi_idx = {blk[3], blk[1:0]};
    assign lo_idx = blk[1:0];

endmodule

// File: rtl/shadow_seg_policy.sv
module shadow_seg_policy
    import shadow_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int IDX_W = $clog2(NSEG)
) (
    input  logic [NSEG-1:0]  seg_en,
    input  logic [NSEG-1:0]  seg_wp,
    input  logic             ext_fallback,
    input  logic [IDX_W-1:0] idx,
    output attr_t            attr
);

    attr_t per_seg [NSEG];

    generate
        for (genvar g = 0; g < NSEG; g++) begin : g_seg
            always_comb begin
                if (seg_en[g] || ext_fallback) begin
                    per_seg[g].rd_int = seg_en[g];
                    per_seg[g].wr_int = !seg_wp[g];
                    per_seg[g].wr_en  = !seg_wp[g];
                end else begin
                    per_seg[g] = ATTR_BUS;
                end
            end
        end
    endgenerate

    assign attr = per_seg[idx];

endmodule

// File: rtl/shadow_attr_decode.sv
module shadow_attr_decode
    import shadow_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] blk_i,
    input  logic [7:0]       sys_cfg_i,
    input  logic [7:0]       hi_seg_en_i,
    input  logic [7:0]       lo_cfg_i,
    output logic             rd_int_o,
    output logic             wr_int_o,
    output logic             wr_en_o
);

    localparam int HALF_HI = NUM_HI_SEG / 2;

    region_t             region;
    logic [HI_IDX_W-1:0] hi_idx;
    logic [LO_IDX_W-1:0] lo_idx;
    logic [NUM_HI_SEG-1:0] hi_wp;
    attr_t lo_attr, hi_attr, fw_attr, nxt, out_q;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{sys_cfg_i[6:5], sys_cfg_i[2:0], lo_cfg_i[7], lo_cfg_i[4]};

    shadow_region_sel u_sel (
        .blk    (blk_i),
        .region (region),
        .hi_idx (hi_idx),
        .lo_idx (lo_idx)
    );

    generate
        for (genvar g = 0; g < NUM_HI_SEG; g++) begin : g_hwp
            assign hi_wp[g] = (g >= HALF_HI) ? sys_cfg_i[3] : sys_cfg_i[4];
        end
    endgenerate

    shadow_seg_policy #(.NSEG(NUM_LO_SEG)) u_lo (
        .seg_en       (lo_cfg_i[NUM_LO_SEG-1:0]),
        .seg_wp       ({NUM_LO_SEG{lo_cfg_i[5]}}),
        .ext_fallback (lo_cfg_i[6]),
        .idx          (lo_idx),
        .attr         (lo_attr)
    );

    shadow_seg_policy #(.NSEG(NUM_HI_SEG)) u_hi (
        .seg_en       (hi_seg_en_i),
        .seg_wp       (hi_wp),
        .ext_fallback (lo_cfg_i[6]),
        .idx          (hi_idx),
        .attr         (hi_attr)
    );

    always_comb begin
        fw_attr.rd_int = !sys_cfg_i[7];
        fw_attr.wr_int = sys_cfg_i[7];
        fw_attr.wr_en  = sys_cfg_i[7];
    end

    always_comb begin
        nxt = ATTR_BUS;
        unique case (region)
            RGN_ADAPTER:  nxt = lo_attr;
            RGN_UPPER:    nxt = hi_attr;
            RGN_FIRMWARE: nxt = fw_attr;
            default:      nxt = ATTR_BUS;
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= ATTR_ZERO;
                else        out_q <= nxt;
            end

            AST_FW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                (blk_i[5:2] == 4'b1111 && sys_cfg_i[7]) |=> (!rd_int_o && wr_int_o && wr_en_o)); // R9
        end else begin : g_comb
            always_comb out_q = nxt;
        end
    endgenerate

    assign rd_int_o = out_q.rd_int;
    assign wr_int_o = out_q.wr_int;
    assign wr_en_o  = out_q.wr_en;

    AST_OUTSIDE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_i[5:4] != 2'b11) |-> (nxt == ATTR_BUS)); // R1
    AST_FW_EXT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_i[5:2] == 4'b1111 && sys_cfg_i[7]) |-> (!nxt.rd_int && nxt.wr_int)); // R2
    AST_FW_DROP_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_i[5:2] == 4'b1111 && !sys_cfg_i[7]) |-> (nxt.rd_int && !nxt.wr_en)); // R3
    AST_HI_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_UPPER && hi_seg_en_i[hi_idx]) |-> nxt.rd_int); // R4
    AST_NO_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_ADAPTER && !lo_cfg_i[lo_idx] && !lo_cfg_i[6]) |-> (nxt == ATTR_BUS)); // R7
    AST_DROP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_o |-> !wr_int_o); // R10

endmodule

// File: tb/sim_shadow_attr_decode.sv
module sim_shadow_attr_decode;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] blk = '0;
    logic [7:0] sys = '0, hi = '0, lo = '0;
    logic       rd_int, wr_int, wr_en;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    shadow_attr_decode u0 (
        .clk(clk), .rst_n(rst_n), .blk_i(blk), .sys_cfg_i(sys),
        .hi_seg_en_i(hi), .lo_cfg_i(lo),
        .rd_int_o(rd_int), .wr_int_o(wr_int), .wr_en_o(wr_en)
    );

    // Behavioural reference: encoding {rd_int, wr_int, wr_en}.
    function automatic void model(input int b, input logic [7:0] s, input logic [7:0] h,
                                  input logic [7:0] l, output logic [2:0] e, output string t);
        int a = b * 16384;
        int k;
        logic on, prot;
        if (a < 'hC0000) begin
            e = 3'b001; t = "R1";
        end else if (a >= 'hF0000) begin
            e = s[7] ? 3'b011 : 3'b100; t = s[7] ? "R2" : "R3";
        end else begin
            if (a < 'hD0000) begin
                k = (a - 'hC0000) / 16384; on = l[k]; prot = l[5]; t = "R8";
            end else begin
                k = (a - 'hD0000) / 16384; on = h[k];
                prot = (a >= 'hE0000) ? s[3] : s[4]; t = "R4 R5";
            end
            if (on)        e = {1'b1, prot ? 2'b00 : 2'b11};
            else if (l[6]) begin e = {1'b0, prot ? 2'b00 : 2'b11}; t = "R6"; end
            else           begin e = 3'b001; t = "R7"; end
        end
    endfunction

    task automatic compare();
        logic [2:0] e;
        string t;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({rd_int, wr_int, wr_en} !== e) begin
            errors++;
            $display("FAIL %s (R9 timing): got %b expected %b", t, {rd_int, wr_int, wr_en}, e);
        end
        checks++;
        if (!wr_en && wr_int) begin
            errors++;
            $display("FAIL R10: got wr_en=%b wr_int=%b expected wr_int=0", wr_en, wr_int);
        end
    endtask

    task automatic step(input logic [5:0] b, input logic [7:0] s, input logic [7:0] h, input logic [7:0] l);
        logic [2:0] e;
        string t;
        @(negedge clk);
        compare();
        blk = b; sys = s; hi = h; lo = l;
        model(int'(b), s, h, l, e, t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Reset state: outputs zero even with an external-region input applied (R9).
        blk = 6'd3; sys = 8'hFF; lo = 8'hFF; hi = 8'hFF;
        repeat (3) @(negedge clk);
        checks++;
        if ({rd_int, wr_int, wr_en} !== 3'b000) begin
            errors++;
            $display("FAIL R9 reset: got %b expected 000", {rd_int, wr_int, wr_en});
        end
        rst_n = 1'b1;

        // Low memory and firmware segment (R1, R2, R3).
        for (int b = 0; b < 64; b++) begin
            step(6'(b), 8'h80, 8'hFF, 8'h7F);
            step(6'(b), 8'h00, 8'h00, 8'h00);
        end

        // One-hot walks over every segment with each protect/fallback mix (R4..R8).
        for (int m = 0; m < 8; m++) begin
            for (int bit_i = 0; bit_i < 12; bit_i++) begin
                for (int b = 48; b < 64; b++) begin
                    logic [7:0] s, h, l;
                    s = {1'b0, 3'b000, m[0], m[1], 3'b000};
                    l = {1'b0, m[2], m[0], 1'b0, 4'b0000};
                    h = '0;
                    if (bit_i < 4) l[bit_i] = 1'b1;
                    else           h[bit_i - 4] = 1'b1;
                    step(6'(b), s, h, l);
                end
            end
        end

        // Random mixes.
        for (int n = 0; n < 3000; n++) begin
            step(6'($urandom_range(40, 63)), 8'($urandom), 8'($urandom), 8'($urandom));
        end

        @(negedge clk);
        compare();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule